// File: doc/BRIEF.md
# Accumulator Operand-Free Instruction Executor

This block carries out the twelve instructions of a 16-bit accumulator machine that need no memory operand. The low twelve bits of the instruction word select the operation, one bit per operation. When the sequencer reaches the execute step, it presents that field together with the present accumulator, extend bit and program counter values and raises a one-cycle execute strobe. One clock later the unit shows the new accumulator and extend bit. It also shows the program counter value to write back, which is one higher when a skip condition was met.

A run flag models the machine's start-stop flip-flop. The halt operation clears it. Only the external set input turns it back on. While the flag is clear, execute strobes are not accepted. An operation field that does not have exactly one bit set is reported as illegal. In that case every value passes through unchanged and the run flag is left alone.

Top module: `acc_regop_unit`

## Requirements
- R1: After reset the flag `running` is 0, `res_vld`, `skip_out` and `illegal_out` are 0, and `ac_out`, `e_out` and `pc_out` are all zero.
- R2: A one-cycle pulse on `run_set` makes `running` 1 at the next clock edge. While `running` is 0, `exec_en` is ignored: `res_vld` stays 0 and all result outputs keep their values.
- R3: Bit 11 of `op_bits` clears the accumulator and leaves E unchanged. Bit 10 clears E and leaves the accumulator unchanged.
- R4: Bit 9 inverts every accumulator bit. Bit 8 inverts E.
- R5: Bit 7 rotates right through E: the new accumulator is {old E, old AC[15:1]} and the new E is the old AC[0].
- R6: Bit 6 rotates left through E: the new accumulator is {old AC[14:0], old E} and the new E is the old AC[15].
- R7: Bit 5 adds one to the accumulator, wrapping from 16'hFFFF to 16'h0000, and leaves E unchanged.
- R8: Bit 4 skips when AC[15] is 0 and bit 3 skips when AC[15] is 1. A skip sets `skip_out` to 1 and `pc_out` to `pc_in`+1, which wraps to 0 at 12 bits. With no skip, `pc_out` equals `pc_in`. AC and E are unchanged.
- R9: Bit 2 skips when all 16 accumulator bits are 0. Bit 1 skips when E is 0. Both follow the skip rules of R8.
- R10: Bit 0 (halt) clears `running` at the same edge that raises `res_vld`. If `run_set` is high in that cycle, `running` stays 1.
- R11: If `op_bits` does not have exactly one bit set, `illegal_out` is 1, `skip_out` is 0, the outputs equal `ac_in`, `e_in` and `pc_in`, and `running` is not changed.
- R12: Results appear at the clock edge that samples an accepted strobe, with `res_vld` high for that one cycle. Without a strobe, the result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Execute strobe for the execute step |
| op_bits | input | 12 | One-hot operation field |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current extend bit |
| pc_in | input | 12 | Current program counter |
| run_set | input | 1 | External request to set the run flag |
| ac_out | output | 16 | Resulting accumulator |
| e_out | output | 1 | Resulting extend bit |
| pc_out | output | 12 | Program counter to write back |
| skip_out | output | 1 | Skip was taken |
| illegal_out | output | 1 | Operation field was not one-hot |
| res_vld | output | 1 | Result strobe |
| running | output | 1 | Run flag |

## Verification
The bound checker watches several properties on every cycle. A result strobe must follow an accepted execute strobe. A skip must advance the counter by exactly one. An illegal field must pass all values through. The increment and zero-skip results must match the sampled inputs. The run flag may rise only after a set request, and halt must clear it. The exact bit patterns of the rotates and complements are shown only by the bench's vector table, and so are the edge values of the sign and zero tests. Two other behaviours also depend on stimulus ordering and are covered only by the bench's directed scenarios: strobes ignored while halted, and set winning over halt.

// File: rtl/acc_regop_pkg.sv
package acc_regop_pkg;
  localparam int OP_W  = 12;
  // positions of the operation select bits; the decoder and the bench depend on them
  localparam int B_CLA = 11;
  localparam int B_CLE = 10;
  localparam int B_CMA = 9;
  localparam int B_CME = 8;
  localparam int B_RR  = 7;
  localparam int B_RL  = 6;
  localparam int B_INC = 5;
  localparam int B_SPS = 4;
  localparam int B_SNG = 3;
  localparam int B_SZA = 2;
  localparam int B_SZE = 1;
  localparam int B_HLT = 0;
endpackage

// File: rtl/acc_regop_rstsync.sv
module acc_regop_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/acc_regop_decode.sv
module acc_regop_decode
  import acc_regop_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            legal_o,
  output logic [OP_W-1:0] sel_o
);
  logic [OP_W-1:0] low_cleared;

  always_comb begin
    low_cleared = op_i & (op_i - OP_W'(1));
    legal_o     = (op_i != '0) && (low_cleared == '0);
    sel_o       = legal_o ? op_i : '0;
  end
endmodule

// File: rtl/acc_regop_alu.sv
module acc_regop_alu
  import acc_regop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic [OP_W-1:0] sel_i,
  input  logic [DW-1:0]   ac_i,
  input  logic            e_i,
  input  logic [AW-1:0]   pc_i,
  output logic [DW-1:0]   ac_o,
  output logic            e_o,
  output logic [AW-1:0]   pc_o,
  output logic            skip_o,
  output logic            halt_o
);
  localparam int MSB = DW - 1;
  localparam int NSK = 4;

  logic [NSK-1:0] cond;
  logic [NSK-1:0] ena;
  logic           ac_zero;

  assign ac_zero = (ac_i == '0);
  assign cond    = {~ac_i[MSB], ac_i[MSB], ac_zero, ~e_i};
  assign ena     = {sel_i[B_SPS], sel_i[B_SNG], sel_i[B_SZA], sel_i[B_SZE]};

  always_comb begin
    ac_o   = ac_i;
    e_o    = e_i;
    halt_o = sel_i[B_HLT];
    skip_o = |(cond & ena);
    pc_o   = skip_o ? pc_i + AW'(1) : pc_i;
    if (sel_i[B_CLA]) ac_o = '0;
    if (sel_i[B_CLE]) e_o  = 1'b0;
    if (sel_i[B_CMA]) ac_o = ~ac_i;
    if (sel_i[B_CME]) e_o  = ~e_i;
    if (sel_i[B_RR]) begin
      ac_o = {e_i, ac_i[MSB:1]};
      e_o  = ac_i[0];
    end
    if (sel_i[B_RL]) begin
      ac_o = {ac_i[MSB-1:0], e_i};
      e_o  = ac_i[MSB];
    end
    if (sel_i[B_INC]) ac_o = ac_i + DW'(1);
  end
endmodule

// File: rtl/acc_regop_runctl.sv
module acc_regop_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic run_o
);
  logic run_d, run_q;

  always_comb begin
    run_d = run_q;
    if (clr_i) run_d = 1'b0;
    if (set_i) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run_o = run_q;
endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
  import acc_regop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [OP_W-1:0] op_bits,
  input  logic [DW-1:0]   ac_in,
  input  logic            e_in,
  input  logic [AW-1:0]   pc_in,
  input  logic            run_set,
  output logic [DW-1:0]   ac_out,
  output logic            e_out,
  output logic [AW-1:0]   pc_out,
  output logic            skip_out,
  output logic            illegal_out,
  output logic            res_vld,
  output logic            running
);
  logic            rst_n_s;
  logic            legal;
  logic [OP_W-1:0] sel;
  logic [DW-1:0]   alu_ac;
  logic            alu_e;
  logic [AW-1:0]   alu_pc;
  logic            alu_skip;
  logic            alu_halt;
  logic            accept;
  logic            run_q;

  logic [DW-1:0] ac_d, ac_q;
  logic          e_d, e_q;
  logic [AW-1:0] pc_d, pc_q;
  logic          skip_d, skip_q;
  logic          ill_d, ill_q;
  logic          vld_q;

  acc_regop_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  acc_regop_decode u_dec (
    .op_i(op_bits), .legal_o(legal), .sel_o(sel)
  );

  acc_regop_alu #(.DW(DW), .AW(AW)) u_alu (
    .sel_i(sel), .ac_i(ac_in), .e_i(e_in), .pc_i(pc_in),
    .ac_o(alu_ac), .e_o(alu_e), .pc_o(alu_pc),
    .skip_o(alu_skip), .halt_o(alu_halt)
  );

  assign accept = exec_en & run_q;

  acc_regop_runctl u_run (
    .clk(clk), .rst_n(rst_n_s), .set_i(run_set),
    .clr_i(accept & alu_halt), .run_o(run_q)
  );

  // next-state selection: the decoder already zeroes sel on an illegal field
  always_comb begin
    ac_d   = ac_q;
    e_d    = e_q;
    pc_d   = pc_q;
    skip_d = skip_q;
    ill_d  = ill_q;
    if (accept) begin
      ac_d   = alu_ac;
      e_d    = alu_e;
      pc_d   = alu_pc;
      skip_d = alu_skip;
      ill_d  = ~legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ac_q   <= '0;
      e_q    <= 1'b0;
      pc_q   <= '0;
      skip_q <= 1'b0;
      ill_q  <= 1'b0;
    end else if (accept) begin
      ac_q   <= ac_d;
      e_q    <= e_d;
      pc_q   <= pc_d;
      skip_q <= skip_d;
      ill_q  <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= accept;
  end

  assign ac_out      = ac_q;
  assign e_out       = e_q;
  assign pc_out      = pc_q;
  assign skip_out    = skip_q;
  assign illegal_out = ill_q;
  assign res_vld     = vld_q;
  assign running     = run_q;
endmodule

// File: rtl/acc_regop_chk.sv
module acc_regop_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          exec_en,
  input logic [11:0]   op_bits,
  input logic [DW-1:0] ac_in,
  input logic          e_in,
  input logic [AW-1:0] pc_in,
  input logic          run_set,
  input logic [DW-1:0] ac_out,
  input logic          e_out,
  input logic [AW-1:0] pc_out,
  input logic          skip_out,
  input logic          illegal_out,
  input logic          res_vld,
  input logic          running
);
  // R12
  vld_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_vld |-> $past(exec_en && running));

  // R8
  skip_bumps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && skip_out) |-> (pc_out == $past(pc_in) + AW'(1)));

  // R11
  illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && illegal_out) |-> (ac_out == $past(ac_in) && e_out == $past(e_in)
                                  && pc_out == $past(pc_in) && !skip_out));

  // R11
  illegal_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && illegal_out) |-> running);

  // R7
  inc_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && $past(op_bits) == 12'h020) |->
      (ac_out == $past(ac_in) + DW'(1) && e_out == $past(e_in)));

  // R9
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && $past(op_bits) == 12'h004) |-> (skip_out == ($past(ac_in) == '0)));

  // R2
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(running) |-> $past(run_set));

  // R10
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && $past(op_bits) == 12'h001 && !$past(run_set)) |-> !running);
endmodule

bind acc_regop_unit acc_regop_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_acc_regop_unit.sv
module test_acc_regop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [11:0] op_bits = '0;
  logic [15:0] ac_in = '0;
  logic        e_in = 1'b0;
  logic [11:0] pc_in = '0;
  logic        run_set = 1'b0;
  logic [15:0] ac_out;
  logic        e_out;
  logic [11:0] pc_out;
  logic        skip_out, illegal_out, res_vld, running;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_regop_unit i_acc_regop_unit (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_bits(op_bits),
    .ac_in(ac_in), .e_in(e_in), .pc_in(pc_in), .run_set(run_set),
    .ac_out(ac_out), .e_out(e_out), .pc_out(pc_out), .skip_out(skip_out),
    .illegal_out(illegal_out), .res_vld(res_vld), .running(running)
  );

  // op, ac, e, pc, expected ac, e, pc, skip, illegal
  localparam int NV = 21;
  localparam logic [71:0] TBL [NV] = '{
    {12'h800, 16'h1234, 1'b1, 12'h010, 16'h0000, 1'b1, 12'h010, 1'b0, 1'b0},
    {12'h400, 16'hABCD, 1'b1, 12'h020, 16'hABCD, 1'b0, 12'h020, 1'b0, 1'b0},
    {12'h200, 16'h0F0F, 1'b0, 12'h030, 16'hF0F0, 1'b0, 12'h030, 1'b0, 1'b0},
    {12'h100, 16'h5555, 1'b0, 12'h040, 16'h5555, 1'b1, 12'h040, 1'b0, 1'b0},
    {12'h080, 16'h8001, 1'b0, 12'h050, 16'h4000, 1'b1, 12'h050, 1'b0, 1'b0},
    {12'h080, 16'h0002, 1'b1, 12'h051, 16'h8001, 1'b0, 12'h051, 1'b0, 1'b0},
    {12'h040, 16'h8001, 1'b0, 12'h060, 16'h0002, 1'b1, 12'h060, 1'b0, 1'b0},
    {12'h040, 16'h4000, 1'b1, 12'h061, 16'h8001, 1'b0, 12'h061, 1'b0, 1'b0},
    {12'h020, 16'hFFFF, 1'b1, 12'h070, 16'h0000, 1'b1, 12'h070, 1'b0, 1'b0},
    {12'h020, 16'h00FF, 1'b0, 12'h071, 16'h0100, 1'b0, 12'h071, 1'b0, 1'b0},
    {12'h010, 16'h7FFF, 1'b0, 12'h0FF, 16'h7FFF, 1'b0, 12'h100, 1'b1, 1'b0},
    {12'h010, 16'h8000, 1'b1, 12'h0FF, 16'h8000, 1'b1, 12'h0FF, 1'b0, 1'b0},
    {12'h008, 16'h8000, 1'b0, 12'hFFF, 16'h8000, 1'b0, 12'h000, 1'b1, 1'b0},
    {12'h008, 16'h0001, 1'b1, 12'h123, 16'h0001, 1'b1, 12'h123, 1'b0, 1'b0},
    {12'h004, 16'h0000, 1'b1, 12'h200, 16'h0000, 1'b1, 12'h201, 1'b1, 1'b0},
    {12'h004, 16'h0100, 1'b0, 12'h200, 16'h0100, 1'b0, 12'h200, 1'b0, 1'b0},
    {12'h002, 16'h0000, 1'b0, 12'h300, 16'h0000, 1'b0, 12'h301, 1'b1, 1'b0},
    {12'h002, 16'hFFFF, 1'b1, 12'h300, 16'hFFFF, 1'b1, 12'h300, 1'b0, 1'b0},
    {12'h000, 16'h1111, 1'b1, 12'h400, 16'h1111, 1'b1, 12'h400, 1'b0, 1'b1},
    {12'h030, 16'h2222, 1'b0, 12'h401, 16'h2222, 1'b0, 12'h401, 1'b0, 1'b1},
    {12'hFFF, 16'hFFFF, 1'b1, 12'hFFF, 16'hFFFF, 1'b1, 12'hFFF, 1'b0, 1'b1}
  };

  function automatic string tag_of(logic [11:0] op);
    case (op)
      12'h800, 12'h400: return "R3";
      12'h200, 12'h100: return "R4";
      12'h080:          return "R5";
      12'h040:          return "R6";
      12'h020:          return "R7";
      12'h010, 12'h008: return "R8";
      12'h004, 12'h002: return "R9";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [11:0] op, input logic [15:0] ac,
                      input logic e, input logic [11:0] pc, input logic set);
    @(negedge clk);
    exec_en = 1'b1; op_bits = op; ac_in = ac; e_in = e; pc_in = pc; run_set = set;
    @(negedge clk);
    exec_en = 1'b0; run_set = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk);
    run_set = 1'b1;
    @(negedge clk);
    run_set = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [30:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check({ac_out, e_out, pc_out, skip_out, illegal_out, res_vld, running} == '0, "R1",
          {ac_out, e_out, pc_out, skip_out, illegal_out, res_vld, running}, 0);

    // R2: strobe ignored while halted
    exec(12'h200, 16'h00FF, 1'b1, 12'h555, 1'b0);
    check(!res_vld && ac_out == 16'h0000 && pc_out == 12'h000, "R2",
          {res_vld, ac_out, pc_out}, 0);

    // R2: set request starts running
    pulse_set();
    check(running == 1'b1, "R2", running, 1);

    // vector table, R3 to R9 and R11
    for (int k = 0; k < NV; k++) begin
      logic [71:0] v;
      v = TBL[k];
      exec(v[71:60], v[59:44], v[43], v[42:31], 1'b0);
      check(res_vld && {ac_out, e_out, pc_out, skip_out, illegal_out} == v[30:0],
            tag_of(v[71:60]), {res_vld, ac_out, e_out, pc_out, skip_out, illegal_out},
            {1'b1, v[30:0]});
    end
    // R11: illegal fields left the run flag alone
    check(running == 1'b1, "R11", running, 1);

    // R12: no strobe, outputs hold
    snap = {ac_out, e_out, pc_out, skip_out, illegal_out};
    @(negedge clk);
    @(negedge clk);
    check(!res_vld && {ac_out, e_out, pc_out, skip_out, illegal_out} == snap, "R12",
          {res_vld, ac_out, e_out, pc_out, skip_out, illegal_out}, {1'b0, snap});

    // R10: halt
    exec(12'h001, 16'h3C3C, 1'b1, 12'h0AB, 1'b0);
    check(res_vld && !running && ac_out == 16'h3C3C && pc_out == 12'h0AB && !skip_out,
          "R10", {res_vld, running, ac_out, pc_out}, {1'b1, 1'b0, 16'h3C3C, 12'h0AB});

    // R2: strobe after halt ignored, outputs unchanged
    exec(12'h800, 16'h7777, 1'b0, 12'h001, 1'b0);
    check(!res_vld && ac_out == 16'h3C3C && !running, "R2",
          {res_vld, ac_out, running}, {1'b0, 16'h3C3C, 1'b0});

    // R10: set wins over halt in the same cycle
    pulse_set();
    exec(12'h001, 16'h0001, 1'b0, 12'h002, 1'b1);
    check(res_vld && running, "R10", {res_vld, running}, 2'b11);

    // R12: result visible exactly one edge after an accepted strobe, then strobe drops
    exec(12'h020, 16'h0009, 1'b0, 12'h010, 1'b0);
    check(res_vld && ac_out == 16'h000A, "R12", {res_vld, ac_out}, {1'b1, 16'h000A});
    @(negedge clk);
    check(!res_vld && ac_out == 16'h000A, "R12", {res_vld, ac_out}, {1'b0, 16'h000A});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule